// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

A per-core timer built from two parts. One is a free-running counter that steps forward by one on each enabled tick and wraps around at the top of its range. The other is a compare register that software can write. When the running count becomes equal to the compare value, a sticky pending flag is set. That flag drives a level interrupt line. Software sees the flag at a fixed bit of a status word. Software acknowledges the interrupt by writing the compare register, and this is the only way to clear the flag.

The unit tests for exact equality only. Software can therefore decide whether a deadline has passed by taking the signed difference of count minus compare, and wrap-around does not upset that test. A deadline that the counter has already passed does not fire until the counter wraps around and comes back to it. The `count_en` input gates each increment, so a slower prescaled tick can drive the counter.

Register access uses one write port and one read port, both plain. A write is taken in every cycle where `reg_we` is high. A read returns data combinationally from `reg_raddr`. Neither port has back-pressure, and neither needs any.

Top module: `count_compare_timer`

## Requirements
- R1: While `rst_n` is low, and right after it is released, count reads 0, compare reads 0, the status word reads 0 and `irq` is 0.
- R2: With no count write in a cycle, the count steps up by exactly 1 at a clock edge where `count_en` is 1, and keeps its value where `count_en` is 0. The count wraps from 0xFFFFFFFF to 0.
- R3: A write to address 0 (count) loads `reg_wdata` into the count at that edge. The load takes priority over the increment.
- R4: When the count value becomes equal to the compare value, `irq` goes high in the cycle after the cycle in which they are equal. Equality is exact, with no greater-than test.
- R5: The pending flag is sticky. `irq` stays high after the count moves past the compare value, until there is a compare write.
- R6: Any write to address 1 (compare) clears the pending flag, including a write of the value already held. `irq` is low in the cycle after the write.
- R7: If a compare write and a match fall in the same cycle, the write wins and the flag ends up cleared. Equality with the newly written value is detected from the next cycle onward, even if the count already equals that value.
- R8: A read of address 2 (status) returns the pending flag at bit 30 and zero in every other bit. Writes to address 2 change nothing.
- R9: A count write leaves the pending flag unchanged.
- R10: The equality of count and compare that exists at reset raises no interrupt. A compare value that lies behind the count fires only after the counter wraps around and reaches it.
- R11: Reads have no side effects. Reading any address, however often, changes neither the count, the compare value nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_en | input | 1 | Tick enable for the counter increment |
| reg_we | input | 1 | Write strobe, taken at the clock edge |
| reg_waddr | input | 2 | Write address: 0 count, 1 compare, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address, same decoding as the write address |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| irq | output | 1 | Registered timer interrupt level |

## Verification
The assertions assume several things about the inputs. `reg_we` and the addresses are never unknown outside reset. At most one register is written per cycle, which the single write port already ensures. Address 3 is never used. The stimulus drives every input on the falling clock edge and reads on the next falling edge, so every access is stable around the rising edge. It uses only addresses 0 to 2 and releases reset away from the rising edge. The `count_en` patterns cover held-low stretches, runs of ticks and ticks combined with count writes. The stimulus also includes a compare write in the very cycle of a match, so the priority rule is exercised inside these assumptions.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int unsigned TM_WIDTH    = 32;
  localparam int unsigned TM_ADDR_W   = 2;
  localparam int unsigned TM_PEND_BIT = 30;

  typedef enum logic [TM_ADDR_W-1:0] {
    TM_ADR_COUNT   = 2'd0,
    TM_ADR_COMPARE = 2'd1,
    TM_ADR_STATUS  = 2'd2
  } tm_addr_e;
endpackage

// File: rtl/tm_counter.sv
module tm_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (step_en) begin
      value <= value + ONE;
    end
  end
endmodule

// File: rtl/tm_compare_reg.sv
module tm_compare_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end
  end
endmodule

// File: rtl/tm_pending.sv
module tm_pending #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmp,
  input  logic             ack,
  output logic             pend
);
  logic equal_now;
  logic equal_seen;

  assign equal_now = (cnt == cmp);

  // equal_seen starts high so that the equality present at reset is not reported.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      equal_seen <= 1'b1;
    end else if (ack) begin
      pend       <= 1'b0;
      equal_seen <= 1'b0;
    end else begin
      equal_seen <= equal_now;
      if (equal_now && !equal_seen) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/count_compare_timer.sv
module count_compare_timer
  import tm_pkg::*;
#(
  parameter int unsigned WIDTH    = TM_WIDTH,
  parameter int unsigned ADDR_W   = TM_ADDR_W,
  parameter int unsigned PEND_BIT = TM_PEND_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [WIDTH-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [WIDTH-1:0]  reg_rdata,
  output logic              irq
);
  logic             cnt_wr;
  logic             cmp_wr;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] cmp_q;
  logic             pend_q;
  logic [WIDTH-1:0] status_w;

  assign cnt_wr = reg_we && (reg_waddr == ADDR_W'(TM_ADR_COUNT));
  assign cmp_wr = reg_we && (reg_waddr == ADDR_W'(TM_ADR_COMPARE));

  tm_counter #(.WIDTH(WIDTH)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (count_en),
    .load     (cnt_wr),
    .load_val (reg_wdata),
    .value    (count_q)
  );

  tm_compare_reg #(.WIDTH(WIDTH)) u_compare (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmp_wr),
    .load_val (reg_wdata),
    .value    (cmp_q)
  );

  tm_pending #(.WIDTH(WIDTH)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (count_q),
    .cmp  (cmp_q),
    .ack  (cmp_wr),
    .pend (pend_q)
  );

  always_comb begin
    status_w           = '0;
    status_w[PEND_BIT] = pend_q;
  end

  always_comb begin
    unique case (reg_raddr)
      ADDR_W'(TM_ADR_COUNT):   reg_rdata = count_q;
      ADDR_W'(TM_ADR_COMPARE): reg_rdata = cmp_q;
      ADDR_W'(TM_ADR_STATUS):  reg_rdata = status_w;
      default:                 reg_rdata = '0;
    endcase
  end

  assign irq = pend_q;
endmodule

// File: rtl/count_compare_timer_chk.sv
module count_compare_timer_chk #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned PEND_BIT = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              count_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [ADDR_W-1:0] reg_raddr,
  input logic [WIDTH-1:0]  reg_rdata,
  input logic              irq,
  input logic [WIDTH-1:0]  cnt_v,
  input logic [WIDTH-1:0]  cmp_v
);
  logic wr_cnt;
  logic wr_cmp;
  assign wr_cnt = reg_we && (reg_waddr == ADDR_W'(0));
  assign wr_cmp = reg_we && (reg_waddr == ADDR_W'(1));

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_cnt) |=> (cnt_v == $past(cnt_v) + WIDTH'(1))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr_cnt) |=> $stable(cnt_v)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_v == $past(reg_wdata))); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt_v == cmp_v)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_cmp) |=> irq); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !irq); // R6
  AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == ADDR_W'(2)) |-> (reg_rdata == (WIDTH'(irq) << PEND_BIT))); // R8
endmodule

bind count_compare_timer count_compare_timer_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .PEND_BIT(PEND_BIT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .count_en (count_en),
  .reg_we   (reg_we),
  .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata),
  .reg_raddr(reg_raddr),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .cnt_v    (count_q),
  .cmp_v    (cmp_q)
);

// File: tb/count_compare_timer_tb_top.sv
`timescale 1ns/1ps
module count_compare_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        count_en;
  logic        reg_we;
  logic [1:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [1:0]  reg_raddr;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  count_compare_timer dut_i (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        en;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  // Expected count and irq after each edge. Address 0 is count, 1 is compare, 2 is status.
  localparam vec_t TBL [20] = '{
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R10 equality at reset is silent
    '{1'b0, 1'b1, 2'd1, 32'h5,        32'h0,        1'b0}, // compare = 5
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h1,        1'b0}, // R2
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h2,        1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h3,        1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h4,        1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h5,        1'b0}, // count reaches compare
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h5,        1'b1}, // R4 one cycle later
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h6,        1'b1}, // R5 sticky
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h7,        1'b1},
    '{1'b0, 1'b1, 2'd1, 32'h7,        32'h7,        1'b0}, // R7 write beats match
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h7,        1'b1}, // R7 new value matches
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h7,        1'b1},
    '{1'b0, 1'b1, 2'd1, 32'h7,        32'h7,        1'b0}, // R6 same-value ack
    '{1'b0, 1'b0, 2'd0, 32'h0,        32'h7,        1'b1},
    '{1'b1, 1'b1, 2'd0, 32'h10,       32'h10,       1'b1}, // R3 R9 load over step
    '{1'b1, 1'b1, 2'd1, 32'h20,       32'h11,       1'b0}, // R6
    '{1'b1, 1'b1, 2'd0, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'hFFFF_FFFF, 1'b0},
    '{1'b1, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}  // R2 wrap
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic we, input logic [1:0] a, input logic [31:0] d);
    count_en = en; reg_we = we; reg_waddr = a; reg_wdata = d;
  endtask

  task automatic idle_step(input logic en);
    drive(en, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 2'd0, 32'h0);
    reg_raddr = 2'd0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 count in reset", reg_rdata, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    count_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    reg_raddr = 2'd1; #0.5;
    chk("R1 compare after reset", reg_rdata, 32'h0);
    reg_raddr = 2'd2; #0.5;
    chk("R1 status after reset", reg_rdata, 32'h0);
    reg_raddr = 2'd0;

    for (int i = 0; i < 20; i++) begin
      drive(TBL[i].en, TBL[i].we, TBL[i].addr, TBL[i].wdata);
      @(negedge clk);
      chk($sformatf("R2/R3 count row %0d", i), reg_rdata, TBL[i].exp_cnt);
      chk($sformatf("R4/R5/R6/R7 irq row %0d", i), {31'h0, irq}, {31'h0, TBL[i].exp_irq});
    end

    // R10: a compare value behind the count waits for the wrap. Compare is 0x20 here.
    drive(1'b0, 1'b1, 2'd0, 32'h30); @(negedge clk);
    for (int k = 0; k < 10; k++) idle_step(1'b1);
    chk("R10 passed compare silent", {31'h0, irq}, 32'h0);
    chk("R2 count after run", reg_rdata, 32'h3A);
    drive(1'b1, 1'b1, 2'd0, 32'hFFFF_FFF0); @(negedge clk);
    for (int k = 0; k < 48; k++) idle_step(1'b1);
    chk("R10 at compare, not yet", {31'h0, irq}, 32'h0);
    chk("R10 count at compare", reg_rdata, 32'h20);
    idle_step(1'b0);
    chk("R10 fires after wrap", {31'h0, irq}, 32'h1);

    // R8 status bit and R11 side-effect-free reads
    reg_raddr = 2'd2;
    for (int k = 0; k < 3; k++) idle_step(1'b0);
    chk("R8 status bit 30", reg_rdata, 32'h4000_0000);
    chk("R11 reads keep flag", {31'h0, irq}, 32'h1);
    drive(1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF); @(negedge clk);
    chk("R8 status write ignored", reg_rdata, 32'h4000_0000);
    reg_raddr = 2'd1; #0.5;
    chk("R8 compare untouched by status write", reg_rdata, 32'h20);
    reg_raddr = 2'd0; #0.5;
    chk("R11 count held after reads", reg_rdata, 32'h20);

    // R9 count write with flag set
    drive(1'b0, 1'b1, 2'd0, 32'h1234); @(negedge clk);
    chk("R9 flag survives count write", {31'h0, irq}, 32'h1);
    chk("R3 count loaded", reg_rdata, 32'h1234);

    // R6 ack then R1 reset mid-run
    drive(1'b0, 1'b1, 2'd1, 32'h20); @(negedge clk);
    chk("R6 irq low after ack", {31'h0, irq}, 32'h0);
    idle_step(1'b1);
    rst_n = 1'b0; #0.5;
    chk("R1 count cleared by reset", reg_rdata, 32'h0);
    reg_raddr = 2'd1; #0.5;
    chk("R1 compare cleared by reset", reg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    reg_raddr = 2'd0;
    idle_step(1'b0);
    chk("R10 no irq from reset equality", {31'h0, irq}, 32'h0);
    finish_run();
  end
endmodule